// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block sits in the decode stage of a five-stage integer pipeline. It compares the instruction waiting in the fetch/decode register against the instruction in the decode/execute register. If the older one is a word load, and the younger one reads that load's destination register, the block requests a one-cycle interlock.

During the interlock the PC and the fetch/decode register are held. The decode/execute register is loaded with a bubble instead of the decoded instruction. The bubble is the add of register 0 to register 0 into register 0, with all other stage fields cleared.

There is no bypass from the loaded value to the store data port. A store that depends on the load therefore waits like any other consumer. A branch-misprediction squash arriving in the same cycle wins over the interlock.

The block is purely combinational.

Top module: `load_use_interlock`

## Requirements
- R1: A load is an ID/EX word whose opcode (bits 31:26) is 0x23; its destination register is bits 20:16.
- R2: A consumer with opcode 0x00 (register-register ALU) stalls when bits 25:21 or bits 20:16 equal the load destination.
- R3: A consumer with opcode 0x08 (add immediate) or 0x23 (load) stalls only when bits 25:21 equal the load destination; bits 20:16 are not compared.
- R4: A consumer with opcode 0x2B (store) stalls when its base field (bits 25:21) or its data field (bits 20:16) equals the load destination.
- R5: A consumer with opcode 0x04 (branch if zero) stalls only on a bits 25:21 match.
- R6: A consumer with opcode 0x3F (halt), or any opcode not listed above, never stalls.
- R7: A load whose destination is register 0 never stalls.
- R8: An ID/EX word whose opcode is not 0x23 never stalls.
- R9: `pc_hold`, `ifid_hold` and `bubble_sel` are always equal.
- R10: With `squash` high, all three stall outputs are low whatever the instruction words.
- R11: `bubble_instr` is 0x00000020, the register-0 add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_instr | input | 32 | Instruction word in the fetch/decode register (consumer) |
| idex_instr | input | 32 | Instruction word in the decode/execute register (possible load) |
| squash | input | 1 | Misprediction flush of the two younger stages; overrides the stall |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| bubble_sel | output | 1 | Load the decode/execute register with the bubble instead of the decoded word |
| bubble_instr | output | 32 | Instruction word used for the bubble |

## Verification
The block holds no state, so a decoding error appears on the stall outputs in the same cycle the offending pair of words is presented. A missing stall lets a dependent instruction read a stale register. A spurious stall costs one cycle and changes no architectural result. Both show up as a wrong `bubble_sel` for that input pair alone.

The sweep covers every consumer opcode class against all source-field values and several load destinations, including register 0. A wrong field selection for any opcode therefore shows as a mismatch.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int INSTR_W = 32,
  parameter int OPC_W   = 6,
  parameter int REG_W   = 5
) (
  input  logic [INSTR_W-1:0] ifid_instr,
  input  logic [INSTR_W-1:0] idex_instr,
  input  logic               squash,
  output logic               pc_hold,
  output logic               ifid_hold,
  output logic               bubble_sel,
  output logic [INSTR_W-1:0] bubble_instr
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int SRC1_LSB = OPC_LSB - REG_W;
  localparam int SRC2_LSB = SRC1_LSB - REG_W;

  localparam logic [OPC_W-1:0] OP_ALU  = 6'h00;
  localparam logic [OPC_W-1:0] OP_BRZ  = 6'h04;
  localparam logic [OPC_W-1:0] OP_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OP_LOAD = 6'h23;
  localparam logic [OPC_W-1:0] OP_STOR = 6'h2B;

  logic [OPC_W-1:0] prod_op, cons_op;
  logic [REG_W-1:0] load_dst, cons_a, cons_b;
  logic             is_load, uses_a, uses_b, hit, stall;

  assign prod_op  = idex_instr[INSTR_W-1 -: OPC_W];
  assign load_dst = idex_instr[SRC2_LSB +: REG_W];
  assign cons_op  = ifid_instr[INSTR_W-1 -: OPC_W];
  assign cons_a   = ifid_instr[SRC1_LSB +: REG_W];
  assign cons_b   = ifid_instr[SRC2_LSB +: REG_W];

  assign is_load = (prod_op == OP_LOAD) && (load_dst != '0);

  always_comb begin
    uses_a = 1'b0;
    uses_b = 1'b0;
    case (cons_op)
      OP_ALU, OP_STOR: begin uses_a = 1'b1; uses_b = 1'b1; end
      OP_ADDI, OP_LOAD, OP_BRZ: uses_a = 1'b1;
      default: ;
    endcase
  end

  assign hit   = (uses_a && cons_a == load_dst) || (uses_b && cons_b == load_dst);
  assign stall = is_load && hit && !squash;

  assign pc_hold      = stall;
  assign ifid_hold    = stall;
  assign bubble_sel   = stall;
  assign bubble_instr = INSTR_W'(32'h0000_0020);

  always_comb begin
    if (!$isunknown({ifid_instr, idex_instr, squash})) begin
      a_r9_holds_agree: assert (pc_hold == ifid_hold && ifid_hold == bubble_sel);
      a_r10_squash_wins: assert (!(squash && bubble_sel));
      a_r7_zero_dest_quiet: assert (!(idex_instr[SRC2_LSB +: REG_W] == '0 && bubble_sel));
      a_r8_nonload_quiet: assert (!(idex_instr[INSTR_W-1 -: OPC_W] != OP_LOAD && pc_hold));
      a_r6_halt_quiet: assert (!(ifid_instr[INSTR_W-1 -: OPC_W] == 6'h3F && ifid_hold));
    end
  end

endmodule

// File: tb/tb_load_use_interlock.sv
module tb_load_use_interlock;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] ifid_instr, idex_instr, bubble_instr;
  logic        squash, pc_hold, ifid_hold, bubble_sel;
  int vectors = 0, errors = 0;
  bit done = 0;

  load_use_interlock dut (.*);

  function automatic logic exp_stall(logic [31:0] c, logic [31:0] p, logic sq);
    logic [4:0] d;
    logic a, b;
    d = p[20:16];
    if (sq || p[31:26] != 6'h23 || d == 5'd0) return 1'b0;
    a = (c[25:21] == d);
    b = (c[20:16] == d);
    case (c[31:26])
      6'h00, 6'h2B: return a || b;
      6'h08, 6'h23, 6'h04: return a;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(logic [31:0] c, logic [31:0] p, logic sq, string req);
    logic e;
    @(negedge clk);
    ifid_instr = c; idex_instr = p; squash = sq;
    #5;
    e = exp_stall(c, p, sq);
    vectors++;
    if (pc_hold !== e || ifid_hold !== e || bubble_sel !== e) begin
      errors++;
      $display("FAIL %s: c=%h p=%h sq=%0d got %b%b%b expected %b", req, c, p, sq,
               pc_hold, ifid_hold, bubble_sel, e);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [7];
    logic [4:0] dsts [4];
    string req;
    ops = '{6'h00, 6'h08, 6'h23, 6'h2B, 6'h04, 6'h3F, 6'h3E};
    dsts = '{5'd0, 5'd1, 5'd13, 5'd31};
    ifid_instr = 32'h0000_0020; idex_instr = 32'h0000_0020; squash = 1'b1;
    #5;
    vectors++;
    if (pc_hold !== 1'b0 || bubble_sel !== 1'b0 || bubble_instr !== 32'h0000_0020) begin
      errors++;
      $display("FAIL R11/R10 initial: got %b %h expected 0 00000020", pc_hold, bubble_instr);
    end
    for (int oi = 0; oi < 7; oi++)
      for (int di = 0; di < 4; di++)
        for (int s = 0; s < 1024; s++) begin
          case (ops[oi])
            6'h00: req = "R2";
            6'h08, 6'h23: req = "R3";
            6'h2B: req = "R4";
            6'h04: req = "R5";
            default: req = "R6";
          endcase
          if (dsts[di] == 5'd0) req = "R7";
          apply({ops[oi], s[9:5], s[4:0], 16'h0820}, {6'h23, 5'd2, dsts[di], 16'h0040}, 1'b0, req);
        end
    for (int s = 0; s < 1024; s++) begin
      apply({6'h00, s[9:5], s[4:0], 16'h0820}, {6'h2B, 5'd3, s[4:0], 16'h0010}, 1'b0, "R8");
      apply({6'h2B, s[9:5], s[4:0], 16'h0004}, {6'h00, 5'd4, s[4:0], 16'h0820}, 1'b0, "R8");
      apply({6'h2B, s[9:5], s[4:0], 16'h0004}, {6'h23, 5'd4, s[4:0], 16'h0000}, 1'b1, "R10");
      apply({6'h00, s[4:0], s[9:5], 16'h0820}, {6'h23, 5'd0, s[9:5], 16'h0008}, 1'b0, "R1");
    end
    vectors++;
    if (bubble_instr !== 32'h0000_0020) begin
      errors++;
      $display("FAIL R11: got %h expected 00000020", bubble_instr);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule